// File: doc/BRIEF.md
# Windowed Watchdog Timer with Early Warning

This block is a watchdog timer clocked by a slow clock. Software services it by writing a key byte to a write-only service register. If it is not serviced in time, the block raises a one-cycle reset request for the reset controller. A configurable count can raise an early-warning flag first, and that flag can drive an interrupt.

In window mode, each period starts with a closed interval. A service in that interval is treated as a fault, just like a wrong key byte. The recorded cause of the last reset request tells a timeout apart from an illegal service.

An always-on bit locks the control and configuration registers until the next reset. Synchronisation to another clock is not built. It is represented only as per-field busy bits that stay high for two cycles after a write.

Top module: `wdw_top`

## Requirements
- R1: After reset, these reads return: control (offset 0x0) 0x00, configuration (0x1) 0xBB, warning offset (0x2) 0x0B, interrupt enable (0x5) 0, flag (0x6) 0, busy (0x8) 0. `rst_req` and `irq` are low.
- R2: Configuration bits 3:0 hold a period code n, giving 8·2^n cycles. With window mode off, `rst_req` rises exactly that many cycles after the enabling write (control bit 1) if no service occurs. `rst_cause` then reads 1, meaning timeout.
- R3: Period codes 0xC to 0xF behave as 16384 cycles.
- R4: Writing 0xA5 to the service register (0xC) outside a closed interval restarts the count from zero without a reset request.
- R5: Writing any other byte to the service register while enabled raises `rst_req` on the next cycle, with `rst_cause` 2 (illegal service).
- R6: With window mode on (control bit 2), configuration bits 7:4 give the closed interval with the same encoding. A 0xA5 service during it raises `rst_req` with `rst_cause` 2.
- R7: In window mode, a 0xA5 service after the closed interval restarts the count. An unserviced run then times out after the closed interval plus the period.
- R8: Warning-offset bits 3:0 give a count with the same encoding. The flag (bit 0 at 0x6) sets one cycle after the count equals it. Writing 1 to flag bit 0 clears it.
- R9: `irq` equals flag AND interrupt enable. Writing bit 0 = 1 to 0x5 sets the enable, and writing bit 0 = 1 to 0x4 clears it.
- R10: Once control bit 7 (always-on) is written as 1, writes to the control and configuration registers are ignored until reset.
- R11: A write to control sets busy bits 1, 2 and 3, and a write to the service register sets busy bit 4. Each bit stays high for exactly two cycles.
- R12: Control bits 0 and 6:3 always read as zero.
- R13: `rst_req` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| irq | output | 1 | Early-warning interrupt |
| rst_req | output | 1 | One-cycle system reset request |
| rst_cause | output | 2 | Cause of last request: 1 timeout, 2 illegal service |

## Verification
The bench samples the reset request exactly one cycle before and at the timeout edge. An off-by-one in the count comparison therefore shows up as a request that comes early or late.

In window mode, services are placed on both sides of the closed boundary. A design that ignored the closed interval would accept the early service, and one that used the wrong total limit would time out at the wrong cycle.

The bench also covers several cases that a careless design gets wrong:
- A clamped period code, which a design without the clamp would turn into a very short or wrapped limit.
- Writes made after the lock, which a design without the lock would let through.
- A flag that must survive clearing the interrupt enable.
- Busy bits checked on both cycles, which a design would fail by dropping them early or holding them too long.

// File: rtl/wdw_pkg.sv
// Shared constants, cause encoding and period decode for the windowed watchdog.
package wdw_pkg;
    localparam int MIN_SHIFT = 3;                    // code 0 -> 8 cycles
    localparam int MAX_CODE  = 11;                   // largest distinct code
    localparam int CNT_W     = MIN_SHIFT + MAX_CODE + 2; // holds closed + open sum
    localparam logic [7:0] SVC_KEY = 8'hA5;

    localparam logic [3:0] OFF_CTRL   = 4'h0;
    localparam logic [3:0] OFF_CFG    = 4'h1;
    localparam logic [3:0] OFF_WARN   = 4'h2;
    localparam logic [3:0] OFF_IE_CLR = 4'h4;
    localparam logic [3:0] OFF_IE_SET = 4'h5;
    localparam logic [3:0] OFF_FLAG   = 4'h6;
    localparam logic [3:0] OFF_BUSY   = 4'h8;
    localparam logic [3:0] OFF_SVC    = 4'hC;

    typedef enum logic [1:0] {
        CAUSE_NONE    = 2'd0,
        CAUSE_TIMEOUT = 2'd1,
        CAUSE_BADSVC  = 2'd2
    } cause_e;

    // Convert a 4-bit period code to a cycle count; codes above MAX_CODE clamp.
    function automatic logic [CNT_W-1:0] code_to_cycles(input logic [3:0] code);
        int sh;
        sh = (int'(code) > MAX_CODE) ? MAX_CODE : int'(code);
        return CNT_W'(1) << (sh + MIN_SHIFT);
    endfunction
endpackage

// File: rtl/wdw_regs.sv
// Register file of the watchdog: control, configuration, warning offset,
// interrupt enable, write-1-to-clear flag and busy status.
// Assumes one write per cycle; reads are combinational on addr.
module wdw_regs
    import wdw_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 8,
    parameter int RD_W     = 32,
    parameter int BUSY_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              warn_hit,
    output logic [RD_W-1:0]   rdata,
    output logic              run_en,
    output logic              win_en,
    output logic [3:0]        per_code,
    output logic [3:0]        win_code,
    output logic [3:0]        warn_code,
    output logic              svc_stb,
    output logic              svc_key_ok,
    output logic              irq
);
    localparam int NBUSY  = 4;
    localparam int HOLD_W = $clog2(BUSY_CYC + 1);

    logic       en_q, wen_q, aon_q;
    logic [7:0] cfg_q;
    logic [3:0] warn_q;
    logic       ie_q, flag_q;
    logic       ctrl_wr, cfg_wr;
    logic [NBUSY-1:0] busy_set, busy;

    // Decode of accepted writes; control and config are blocked by the lock.
    assign ctrl_wr    = wr_en && addr == ADDR_W'(OFF_CTRL) && !aon_q;
    assign cfg_wr     = wr_en && addr == ADDR_W'(OFF_CFG)  && !aon_q;
    assign svc_stb    = wr_en && addr == ADDR_W'(OFF_SVC);
    assign svc_key_ok = wdata == SVC_KEY;
    assign busy_set   = {svc_stb, ctrl_wr, ctrl_wr, ctrl_wr};

    // Control, configuration and warning-offset storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            wen_q  <= 1'b0;
            aon_q  <= 1'b0;
            cfg_q  <= 8'hBB;
            warn_q <= 4'hB;
        end else begin
            if (ctrl_wr) begin
                en_q  <= wdata[1];
                wen_q <= wdata[2];
                aon_q <= wdata[7];
            end
            if (cfg_wr) cfg_q <= wdata;
            if (wr_en && addr == ADDR_W'(OFF_WARN)) warn_q <= wdata[3:0];
        end
    end

    // Interrupt enable set/clear pair and warning flag with set priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q   <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            if (wr_en && addr == ADDR_W'(OFF_IE_SET) && wdata[0]) ie_q <= 1'b1;
            else if (wr_en && addr == ADDR_W'(OFF_IE_CLR) && wdata[0]) ie_q <= 1'b0;
            if (warn_hit) flag_q <= 1'b1;
            else if (wr_en && addr == ADDR_W'(OFF_FLAG) && wdata[0]) flag_q <= 1'b0;
        end
    end

    // One hold counter per busy bit: index 0 enable, 1 window, 2 lock, 3 service.
    for (genvar i = 0; i < NBUSY; i++) begin : g_busy
        logic [HOLD_W-1:0] hold;
        // Load the hold time on a write, then count down to idle.
        always_ff @(posedge clk) begin
            if (!rst_n)              hold <= '0;
            else if (busy_set[i])    hold <= HOLD_W'(BUSY_CYC);
            else if (hold != '0)     hold <= hold - HOLD_W'(1);
        end
        assign busy[i] = hold != '0;

        a_r11_busy_two: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(busy[i]) |=> busy[i]);
    end

    // Read-back multiplexer.
    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_W'(OFF_CTRL):   rdata = RD_W'({aon_q, 4'b0000, wen_q, en_q, 1'b0});
            ADDR_W'(OFF_CFG):    rdata = RD_W'(cfg_q);
            ADDR_W'(OFF_WARN):   rdata = RD_W'(warn_q);
            ADDR_W'(OFF_IE_CLR),
            ADDR_W'(OFF_IE_SET): rdata = RD_W'(ie_q);
            ADDR_W'(OFF_FLAG):   rdata = RD_W'(flag_q);
            ADDR_W'(OFF_BUSY):   rdata = RD_W'({busy, 1'b0});
            default:             rdata = '0;
        endcase
    end

    assign run_en    = en_q;
    assign win_en    = wen_q;
    assign per_code  = cfg_q[3:0];
    assign win_code  = cfg_q[7:4];
    assign warn_code = warn_q;
    assign irq       = flag_q & ie_q;

    a_r10_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        aon_q |=> aon_q);
    a_r8_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(warn_hit));
endmodule

// File: rtl/wdw_core.sv
// Watchdog counter: period and closed-window limits, service checking,
// early-warning hit and one-cycle reset request with recorded cause.
// Assumes configuration inputs are stable register outputs.
module wdw_core
    import wdw_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_en,
    input  logic       win_en,
    input  logic [3:0] per_code,
    input  logic [3:0] win_code,
    input  logic [3:0] warn_code,
    input  logic       svc_stb,
    input  logic       svc_key_ok,
    output logic       warn_hit,
    output logic       rst_req,
    output cause_e     cause
);
    logic [W-1:0] cnt, per_cyc, win_cyc, warn_cyc, limit;
    logic         closed;

    // Decode of the period codes into cycle limits.
    always_comb begin
        per_cyc  = W'(code_to_cycles(per_code));
        win_cyc  = W'(code_to_cycles(win_code));
        warn_cyc = W'(code_to_cycles(warn_code));
        limit    = win_en ? win_cyc + per_cyc : per_cyc;
        closed   = win_en && cnt < win_cyc;
        warn_hit = run_en && cnt == warn_cyc;
    end

    // Count, service handling and reset-request generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            rst_req <= 1'b0;
            cause   <= CAUSE_NONE;
        end else begin
            rst_req <= 1'b0;
            if (!run_en) begin
                cnt <= '0;
            end else if (svc_stb) begin
                cnt <= '0;
                if (!svc_key_ok || closed) begin
                    rst_req <= 1'b1;
                    cause   <= CAUSE_BADSVC;
                end
            end else if (cnt >= limit - W'(1)) begin
                cnt     <= '0;
                rst_req <= 1'b1;
                cause   <= CAUSE_TIMEOUT;
            end else begin
                cnt <= cnt + W'(1);
            end
        end
    end

    a_r2_req_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> cause != CAUSE_NONE);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> !rst_req);
    a_r4_key_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && svc_stb && svc_key_ok && !closed) |=> (cnt == '0 && !rst_req));
    a_r5_bad_key: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && svc_stb && !svc_key_ok) |=> (rst_req && cause == CAUSE_BADSVC));
    a_r6_closed_service: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && svc_stb && closed) |=> (rst_req && cause == CAUSE_BADSVC));
endmodule

// File: rtl/wdw_top.sv
// Top of the windowed watchdog: register file plus counter core.
// Assumes a single slow clock; reset controller and clock source are external.
module wdw_top
    import wdw_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int RD_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [RD_W-1:0]   rdata,
    output logic              irq,
    output logic              rst_req,
    output logic [1:0]        rst_cause
);
    logic       run_en, win_en, svc_stb, svc_key_ok, warn_hit;
    logic [3:0] per_code, win_code, warn_code;
    cause_e     cause;

    wdw_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RD_W(RD_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .warn_hit(warn_hit), .rdata(rdata), .run_en(run_en), .win_en(win_en),
        .per_code(per_code), .win_code(win_code), .warn_code(warn_code),
        .svc_stb(svc_stb), .svc_key_ok(svc_key_ok), .irq(irq)
    );

    wdw_core #(.W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .win_en(win_en),
        .per_code(per_code), .win_code(win_code), .warn_code(warn_code),
        .svc_stb(svc_stb), .svc_key_ok(svc_key_ok), .warn_hit(warn_hit),
        .rst_req(rst_req), .cause(cause)
    );

    assign rst_cause = cause;

    a_r13_cause_on_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> rst_cause != 2'd0);
endmodule

// File: tb/tb_wdw_top.sv
// Directed bench for wdw_top: one task per scenario, each checking its results.
module tb_wdw_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [31:0] rdata;
    logic        irq, rst_req;
    logic [1:0]  rst_cause;

    int checks = 0;
    int errors = 0;

    wdw_top dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq(irq), .rst_req(rst_req), .rst_cause(rst_cause)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        rd(4'h0, d); chk("R1 ctrl", d, 32'h00);
        rd(4'h1, d); chk("R1 cfg", d, 32'hBB);
        rd(4'h2, d); chk("R1 warn", d, 32'h0B);
        rd(4'h5, d); chk("R1 ie", d, 32'h0);
        rd(4'h6, d); chk("R1 flag", d, 32'h0);
        rd(4'h8, d); chk("R1 busy", d, 32'h0);
        chk("R1 rst_req", rst_req, 0);
        chk("R1 irq", irq, 0);
    endtask

    task automatic t_timeout();
        do_reset();
        wr(4'h1, 8'h01);           // period 16
        wr(4'h0, 8'h02);           // enable
        idle(15); chk("R2 early", rst_req, 0);
        idle(1);  chk("R2 timeout", rst_req, 1);
        chk("R2 cause", rst_cause, 2'd1);
        idle(1);  chk("R13 pulse", rst_req, 0);
    endtask

    task automatic t_clamp();
        do_reset();
        wr(4'h1, 8'h0F);
        wr(4'h0, 8'h02);
        idle(16383); chk("R3 early", rst_req, 0);
        idle(1);     chk("R3 timeout", rst_req, 1);
    endtask

    task automatic t_key_restart();
        do_reset();
        wr(4'h1, 8'h02);           // period 32
        wr(4'h0, 8'h02);
        idle(20);
        wr(4'hC, 8'hA5);
        chk("R4 no req", rst_req, 0);
        idle(31); chk("R4 restarted", rst_req, 0);
        idle(1);  chk("R4 timeout after restart", rst_req, 1);
    endtask

    task automatic t_bad_key();
        do_reset();
        wr(4'h1, 8'h03);
        wr(4'h0, 8'h02);
        idle(5);
        wr(4'hC, 8'h5A);
        chk("R5 req", rst_req, 1);
        chk("R5 cause", rst_cause, 2'd2);
        idle(1); chk("R13 bad key pulse", rst_req, 0);
    endtask

    task automatic t_window_closed();
        do_reset();
        wr(4'h1, 8'h11);           // closed 16, open 16
        wr(4'h0, 8'h06);
        idle(5);
        wr(4'hC, 8'hA5);
        chk("R6 req", rst_req, 1);
        chk("R6 cause", rst_cause, 2'd2);
    endtask

    task automatic t_window_open();
        do_reset();
        wr(4'h1, 8'h11);
        wr(4'h0, 8'h06);
        idle(20);
        wr(4'hC, 8'hA5);
        chk("R7 open service", rst_req, 0);
        idle(31); chk("R7 early", rst_req, 0);
        idle(1);  chk("R7 timeout", rst_req, 1);
        chk("R7 cause", rst_cause, 2'd1);
    endtask

    task automatic t_warning();
        logic [31:0] d;
        do_reset();
        wr(4'h1, 8'h03);           // period 64
        wr(4'h2, 8'h01);           // warning at 16
        wr(4'h5, 8'h01);
        wr(4'h0, 8'h02);
        idle(16);
        rd(4'h6, d); chk("R8 before", d, 0);
        chk("R9 irq before", irq, 0);
        idle(1);
        rd(4'h6, d); chk("R8 set", d, 1);
        chk("R9 irq set", irq, 1);
        wr(4'h4, 8'h01);
        chk("R9 irq masked", irq, 0);
        rd(4'h6, d); chk("R9 flag kept", d, 1);
        wr(4'h6, 8'h01);
        rd(4'h6, d); chk("R8 cleared", d, 0);
    endtask

    task automatic t_lock();
        logic [31:0] d;
        do_reset();
        wr(4'h0, 8'h7F);
        rd(4'h0, d); chk("R12 reserved zero", d, 32'h06);
        do_reset();
        wr(4'h0, 8'h82);
        rd(4'h0, d); chk("R10 locked value", d, 32'h82);
        wr(4'h0, 8'h00);
        rd(4'h0, d); chk("R10 ctrl ignored", d, 32'h82);
        wr(4'h1, 8'h00);
        rd(4'h1, d); chk("R10 cfg ignored", d, 32'hBB);
    endtask

    task automatic t_busy();
        logic [31:0] d;
        do_reset();
        wr(4'h0, 8'h02);
        rd(4'h8, d); chk("R11 ctrl busy 1", d, 32'h0E);
        idle(1);
        rd(4'h8, d); chk("R11 ctrl busy 2", d, 32'h0E);
        idle(1);
        rd(4'h8, d); chk("R11 ctrl idle", d, 32'h0);
        wr(4'hC, 8'hA5);
        rd(4'h8, d); chk("R11 svc busy", d, 32'h10);
        idle(2);
        rd(4'h8, d); chk("R11 svc idle", d, 32'h0);
    endtask

    initial begin
        idle(3);
        t_reset();
        t_timeout();
        t_clamp();
        t_key_restart();
        t_bad_key();
        t_window_closed();
        t_window_open();
        t_warning();
        t_lock();
        t_busy();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule